// File: doc/BRIEF.md
# Hold/Acknowledge Bus Arbitration Adapter

This block lets a bus-slave protocol engine share a set of internal buses with a processor that offers only a two-wire hold request and hold grant. The engine has three arbitration signals: a bus request, a start-of-transfer strobe and a transfer-acknowledge. The adapter turns these into the processor's hold request. It also returns an active-low enable to the engine once the processor has granted the buses.

At the centre of the block is a single request-state bit. A request from the engine sets it. The processor's hold grant keeps it set after the request is withdrawn. A start strobe or an engine reset clears it. The processor hold is raised when the engine acknowledges a transfer while the bit is clear. The engine enable goes low only while the bit is set and the grant is present.

Every engine-side and processor-side input passes through a two-flop synchronizer clocked by the processor clock. Both outputs are registered.

Top module: `hold_arb_adapter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `cpu_hold` is 0 and `eng_en_n` is 1, and the request state is clear.
- R2: A high `eng_req` sets the request state, so `eng_en_n` goes low when `cpu_hold_ack` is also high.
- R3: When `cpu_hold_ack` is high, the request state stays set after `eng_req` returns low.
- R4: When `cpu_hold_ack` is low and `eng_req` returns low, the request state clears. A grant that arrives later then leaves `eng_en_n` high.
- R5: A high `eng_start`, even for a single cycle, clears the request state.
- R6: A high `eng_rst` clears the request state.
- R7: If a clear (`eng_start` or `eng_rst`) and `eng_req` are sampled in the same cycle, the clear wins and the state ends clear.
- R8: `eng_en_n` is low (engine enabled) only when the synchronized `cpu_hold_ack` is high and the request state is set.
- R9: `cpu_hold` is high only when the synchronized `eng_xfer_ack` is high and the request state is clear.
- R10: Timing of inputs sampled at clock edge k:
  - A change in `eng_xfer_ack` or `cpu_hold_ack` reaches the outputs after edge k+2.
  - A change in the request state caused by `eng_req`, `eng_start` or `eng_rst` reaches `eng_en_n` after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_req | input | 1 | Engine bus request, active high, asynchronous |
| eng_start | input | 1 | Engine start-of-transfer strobe, active high, asynchronous |
| eng_xfer_ack | input | 1 | Engine transfer acknowledge, active high, asynchronous |
| eng_rst | input | 1 | Engine reset indication, active high, asynchronous |
| cpu_hold_ack | input | 1 | Processor hold grant, active high |
| cpu_hold | output | 1 | Hold request to the processor, active high, registered |
| eng_en_n | output | 1 | Enable to the engine, active low, registered |

## Verification
The bench targets the ordering cases of the request state:
- A request withdrawn while the grant is present must keep the engine enabled. A design that dropped the state here would raise `eng_en_n` too early.
- A request withdrawn with no grant must not leave a stale enable when the grant arrives later.
- A request and a clear arriving in the same cycle must end with the state clear. A set-wins design would enable the engine there.

Single-cycle start and reset pulses check that the synchronizer does not swallow short strobes. A cycle-exact check on `cpu_hold` catches a pipeline that has one register too many or too few.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;

    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic eng_rst;
        logic start;
        logic req;
        logic xfer_ack;
        logic hold_ack;
    } hs_t;

    localparam int HS_W = $bits(hs_t);

    // Next value of the request-state bit; a clear takes priority over a set.
    function automatic logic req_next(input logic cur, input logic set,
                                      input logic keep, input logic clr);
        if (clr)
            return 1'b0;
        return set | (cur & keep);
    endfunction

endpackage

// File: rtl/hold_arb_sync.sv
module hold_arb_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst)
            stg[0] <= '0;
        else
            stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stg[i] <= '0;
            else
                stg[i] <= stg[i-1];
        end
    end

    assign q = stg[LAST];
endmodule

// File: rtl/hold_arb_req_state.sv
module hold_arb_req_state
    import hold_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic keep,
    input  logic clr,
    output logic state
);
    always_ff @(posedge clk) begin
        if (rst)
            state <= 1'b0;
        else
            state <= req_next(state, set, keep, clr);
    end
endmodule

// File: rtl/hold_arb_out_stage.sv
module hold_arb_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic state,
    input  logic hold_ack,
    input  logic xfer_ack,
    output logic hold,
    output logic en_n
);
    logic grant_ok;
    logic hold_d;

    always_comb begin
        grant_ok = hold_ack & state;
        hold_d   = xfer_ack & ~state;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= 1'b0;
            en_n <= 1'b1;
        end else begin
            hold <= hold_d;
            en_n <= ~grant_ok;
        end
    end
endmodule

// File: rtl/hold_arb_adapter.sv
module hold_arb_adapter
    import hold_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic eng_req,
    input  logic eng_start,
    input  logic eng_xfer_ack,
    input  logic eng_rst,
    input  logic cpu_hold_ack,
    output logic cpu_hold,
    output logic eng_en_n
);
    hs_t  hs_raw;
    hs_t  hs_sync;
    logic req_state;
    logic s_req, s_start, s_erst, s_xack, s_hack;
    logic clr;

    always_comb begin
        hs_raw.eng_rst  = eng_rst;
        hs_raw.start    = eng_start;
        hs_raw.req      = eng_req;
        hs_raw.xfer_ack = eng_xfer_ack;
        hs_raw.hold_ack = cpu_hold_ack;
    end

    hold_arb_sync #(
        .WIDTH (HS_W),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (hs_raw),
        .q  (hs_sync)
    );

    assign s_req   = hs_sync.req;
    assign s_start = hs_sync.start;
    assign s_erst  = hs_sync.eng_rst;
    assign s_xack  = hs_sync.xfer_ack;
    assign s_hack  = hs_sync.hold_ack;
    assign clr     = s_start | s_erst;

    hold_arb_req_state u_state (
        .clk  (clk),
        .rst  (rst),
        .set  (s_req),
        .keep (s_hack),
        .clr  (clr),
        .state(req_state)
    );

    hold_arb_out_stage u_out (
        .clk     (clk),
        .rst     (rst),
        .state   (req_state),
        .hold_ack(s_hack),
        .xfer_ack(s_xack),
        .hold    (cpu_hold),
        .en_n    (eng_en_n)
    );
endmodule

// File: rtl/hold_arb_adapter_chk.sv
module hold_arb_adapter_chk (
    input logic clk,
    input logic rst,
    input logic hold,
    input logic en_n,
    input logic state,
    input logic s_req,
    input logic s_start,
    input logic s_erst,
    input logic s_xack,
    input logic s_hack
);
    // R1: reset leaves the outputs idle and the state clear
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!hold && en_n && !state));

    // R2: a sampled request with no clear sets the state
    a_r2_req_sets: assert property (@(posedge clk) disable iff (rst)
        (s_req && !s_start && !s_erst) |=> state);

    // R3: a granted state persists without a clear
    a_r3_grant_keeps: assert property (@(posedge clk) disable iff (rst)
        (state && s_hack && !s_start && !s_erst) |=> state);

    // R4: with no request and no grant the state drops
    a_r4_drop_no_grant: assert property (@(posedge clk) disable iff (rst)
        (!s_req && !s_hack) |=> !state);

    // R5, R6, R7: any sampled clear leaves the state clear, even against a request
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (s_start || s_erst) |=> !state);

    // R8: enable only follows a granted, set state
    a_r8_enable_cause: assert property (@(posedge clk) disable iff (rst)
        !en_n |-> $past(s_hack && state));

    // R9: hold only follows an acknowledge with the state clear
    a_r9_hold_cause: assert property (@(posedge clk) disable iff (rst)
        hold |-> $past(s_xack && !state));

    // R8, R9: the two outputs are never active together
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(hold && !en_n));
endmodule

bind hold_arb_adapter hold_arb_adapter_chk i_chk (
    .clk    (clk),
    .rst    (rst),
    .hold   (cpu_hold),
    .en_n   (eng_en_n),
    .state  (req_state),
    .s_req  (s_req),
    .s_start(s_start),
    .s_erst (s_erst),
    .s_xack (s_xack),
    .s_hack (s_hack)
);

// File: tb/test_hold_arb_adapter.sv
module test_hold_arb_adapter;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic eng_req = 0, eng_start = 0, eng_xfer_ack = 0, eng_rst = 0, cpu_hold_ack = 0;
    logic cpu_hold, eng_en_n;

    always #5 clk = ~clk;

    hold_arb_adapter i_hold_arb_adapter (
        .clk         (clk),
        .rst         (rst),
        .eng_req     (eng_req),
        .eng_start   (eng_start),
        .eng_xfer_ack(eng_xfer_ack),
        .eng_rst     (eng_rst),
        .cpu_hold_ack(cpu_hold_ack),
        .cpu_hold    (cpu_hold),
        .eng_en_n    (eng_en_n)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string phase    = "R1";
    bit    done     = 0;

    // Reference model: input bits {erst, holda, xack, start, req} from two edges back.
    logic [4:0] hist[$];
    logic       m_state = 0, m_hold = 0, m_en_n = 1;

    always @(posedge clk) begin
        logic [4:0] cur;
        logic [4:0] d;
        logic       ns;
        cur = {eng_rst, cpu_hold_ack, eng_xfer_ack, eng_start, eng_req};
        if (rst) begin
            hist.delete();
            hist.push_back(5'd0);
            hist.push_back(5'd0);
            m_state = 0; m_hold = 0; m_en_n = 1;
        end else begin
            hist.push_back(cur);
            d = hist.pop_front();
            if (d[4] || d[1])       ns = 0;
            else if (d[0])          ns = 1;
            else if (d[3])          ns = m_state;
            else                    ns = 0;
            m_en_n  = !(d[3] && m_state);
            m_hold  = d[2] && !m_state;
            m_state = ns;
        end
    end

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(phase, "model cpu_hold", cpu_hold, m_hold);
            check(phase, "model eng_en_n", eng_en_n, m_en_n);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        step(3);
        check("R1", "hold in reset", cpu_hold, 1'b0);
        check("R1", "en_n in reset", eng_en_n, 1'b1);
        rst = 0;
        step(1);
        check("R1", "hold after reset", cpu_hold, 1'b0);
        check("R1", "en_n after reset", eng_en_n, 1'b1);

        // R2: request plus grant enables the engine
        phase = "R2";
        cpu_hold_ack = 1; eng_req = 1;
        step(6);
        check("R2", "en_n with req and grant", eng_en_n, 1'b0);

        // R3: state held after request withdrawn while granted
        phase = "R3";
        eng_req = 0;
        step(6);
        check("R3", "en_n kept by grant", eng_en_n, 1'b0);

        // R5: single-cycle start strobe clears
        phase = "R5";
        eng_start = 1; step(1); eng_start = 0;
        step(6);
        check("R5", "en_n after start", eng_en_n, 1'b1);

        // R8: request without grant does not enable; R4: state drops
        phase = "R8";
        cpu_hold_ack = 0; step(4);
        eng_req = 1; step(6);
        check("R8", "en_n with req but no grant", eng_en_n, 1'b1);
        phase = "R4";
        eng_req = 0; step(4);
        cpu_hold_ack = 1; step(6);
        check("R4", "en_n after late grant", eng_en_n, 1'b1);

        // R6: engine reset clears a held state
        phase = "R6";
        eng_req = 1; step(1); eng_req = 0;
        step(6);
        check("R6", "en_n before engine reset", eng_en_n, 1'b0);
        eng_rst = 1; step(1); eng_rst = 0;
        step(6);
        check("R6", "en_n after engine reset", eng_en_n, 1'b1);

        // R7: simultaneous request and clear -> clear wins
        phase = "R7";
        eng_req = 1; eng_start = 1; step(1);
        eng_req = 0; eng_start = 0;
        step(6);
        check("R7", "en_n after req+start", eng_en_n, 1'b1);
        eng_req = 1; eng_rst = 1; step(1);
        eng_req = 0; eng_rst = 0;
        step(6);
        check("R7", "en_n after req+eng_rst", eng_en_n, 1'b1);

        // R9 and R10: hold from acknowledge while clear, exact latency
        phase = "R10";
        cpu_hold_ack = 0; step(6);
        eng_xfer_ack = 1;
        step(2);
        check("R10", "hold after two edges", cpu_hold, 1'b0);
        step(1);
        check("R10", "hold after three edges", cpu_hold, 1'b1);
        phase = "R9";
        step(3);
        check("R9", "hold with ack, state clear", cpu_hold, 1'b1);
        eng_req = 1; step(6);
        check("R9", "hold with ack, state set", cpu_hold, 1'b0);

        // R10: request-driven enable needs one more edge than hold
        phase = "R10";
        eng_req = 0; eng_xfer_ack = 0; eng_start = 1; step(1); eng_start = 0;
        cpu_hold_ack = 1; step(6);
        eng_req = 1;
        step(3);
        check("R10", "en_n after three edges", eng_en_n, 1'b1);
        step(1);
        check("R10", "en_n after four edges", eng_en_n, 1'b0);
        eng_req = 0; step(4);

        // Mixed pattern compared against the model each cycle
        phase = "R8";
        for (int i = 0; i < 200; i++) begin
            eng_req      = ((i * 7) % 5) == 0;
            eng_start    = ((i * 3) % 11) == 4;
            eng_rst      = (i % 37) == 20;
            eng_xfer_ack = ((i / 3) % 2) == 1;
            cpu_hold_ack = ((i / 5) % 3) != 0;
            step(1);
        end
        eng_req = 0; eng_start = 0; eng_rst = 0; eng_xfer_ack = 0; cpu_hold_ack = 0;
        step(6);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule